// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings one rank of single-data-rate SDRAM from power-on to a usable state. After a start pulse it waits for supplies and clocks to settle. It then issues, one command per cycle with timed gaps, a NOP, a precharge of all banks, a fixed burst of auto-refresh commands and a load of the mode register. Finally it moves the rank into normal mode and raises both a done flag and a refresh-enable output, which tell the surrounding controller that it may take over the command bus and start periodic refresh.

Three configuration bits choose the CAS latency, the activate-to-column delay and the precharge time, each as either 2 or 3 clocks. They are captured once, on the cycle that start is accepted. The CAS latency is written into the mode word, the precharge time sets the gap after the precharge-all command, and the activate-to-column delay is passed on as a clock count for the logic that runs after initialization. A mode-select code output shows which kind of command was issued last, so that neighbouring logic can follow the sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, the command pins are deselected ({cs_n,ras_n,cas_n,we_n} = 1111), addr and ba are 0, done and refresh_en are 0, and mode_code is 3'b001.
- R2: Nothing is issued until start is sampled high in the idle state. The first command, a NOP, appears exactly POWERUP_CYC cycles after the edge that sampled start, and the pins stay deselected before that.
- R3: Each command lasts one cycle. The pins {cs_n,ras_n,cas_n,we_n} are 0111 for NOP, 0010 for precharge-all with addr[10]=1, 0001 for auto-refresh, and 0000 for mode-register load. In every other cycle they are 1111 with addr and ba at 0.
- R4: Exactly REF_BURST+3 commands are issued, in this order: NOP, precharge-all, REF_BURST (default 8) auto-refreshes, mode-register load.
- R5: Gaps from one command to the next: NOP to precharge NOP_WAIT_CYC; precharge to first refresh 3 cycles when cfg_rp2=0 and 2 when cfg_rp2=1; after each refresh TRC_CYC; mode-register load to the switch into normal mode MRD_CYC.
- R6: The mode-register load drives ba=0 and addr = (MRS_BYTE_OFS >> BUS_BYTE_SHIFT) with addr[6:4] replaced by the CAS latency: 0x03A when cfg_cl2=0 (latency 3), 0x02A when cfg_cl2=1 (latency 2).
- R7: mode_code takes the code of each issued command in its issue cycle (001 NOP, 010 precharge-all, 100 refresh, 011 mode load) and becomes 000 (normal) exactly MRD_CYC cycles after the mode load.
- R8: done and refresh_en rise together one cycle after mode_code becomes 000. They stay high until reset, and no command is issued afterwards.
- R9: rcd_clks reads 3 when cfg_rcd2 was 0 at start and 2 when it was 1. All three configuration bits are captured when start is accepted, and later changes have no effect on the sequence.
- R10: A start pulse while the sequence is running or after done has no effect on the commands, their timing or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when sampled in idle |
| cfg_cl2 | input | 1 | CAS latency select: 0 = 3 clocks, 1 = 2 clocks |
| cfg_rcd2 | input | 1 | Activate-to-column select: 0 = 3 clocks, 1 = 2 clocks |
| cfg_rp2 | input | 1 | Precharge time select: 0 = 3 clocks, 1 = 2 clocks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines |
| ba | output | BA_W | Bank address |
| mode_code | output | 3 | Kind of the last issued command (mode-select code) |
| rcd_clks | output | 2 | Captured activate-to-column delay in clocks |
| done | output | 1 | Initialization complete |
| refresh_en | output | 1 | Permission for periodic refresh |

## Verification
The bench runs the whole sequence under several combinations of the configuration bits and logs every command cycle with its time. An off-by-one in a wait counter would move a command one cycle early or late and break the exact gap checks. Repeating a command for two cycles, or dropping one refresh from the burst, would change the command count. The bench flips the configuration and pulses start in the middle of a run. A design that samples the configuration live would change the precharge gap or the latency field of the mode word, and one that restarts on a second start would shift every later command. It also checks the MRS address under both latencies, the delay between mode_code reaching 000 and done rising, and that the bus stays quiet both without start and after done.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        MS_NORMAL = 3'b000,
        MS_NOP    = 3'b001,
        MS_PRECH  = 3'b010,
        MS_MRS    = 3'b011,
        MS_CBR    = 3'b100
    } mode_sel_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    typedef struct packed {
        logic cl2;
        logic rcd2;
        logic rp2;
    } timing_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_NOP_W,
        ST_PRE_W,
        ST_CBR_W,
        ST_MRS_W,
        ST_NORM,
        ST_DONE
    } seq_state_e;

    localparam pin_cmd_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Strobe pattern for a command; an idle cycle deselects the rank.
    function automatic pin_cmd_t encode_pins(input mode_sel_e m, input logic issue);
        pin_cmd_t p;
        p = PINS_DESEL;
        if (issue) begin
            p.cs_n = 1'b0;
            unique case (m)
                MS_PRECH: begin p.ras_n = 1'b0; p.we_n = 1'b0; end
                MS_CBR:   begin p.ras_n = 1'b0; p.cas_n = 1'b0; end
                MS_MRS:   begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b0; end
                default:  ;
            endcase
        end
        return p;
    endfunction

    // A select bit of 1 means the short setting (2 clocks), 0 means 3 clocks.
    function automatic logic [1:0] clocks_of(input logic sel);
        return sel ? 2'd2 : 2'd3;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sis_wait_timer.sv
module sis_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sis_seq_fsm.sv
module sis_seq_fsm
    import sdram_init_pkg::*;
#(
    parameter int POWERUP_CYC  = 40000,
    parameter int NOP_WAIT_CYC = 200,
    parameter int TRC_CYC      = 7,
    parameter int MRD_CYC      = 2,
    parameter int REF_BURST    = 8,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  timing_cfg_t      cfg,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             cmd_vld,
    output mode_sel_e        cmd_sel,
    output logic             go_normal,
    output logic             capture,
    output logic             in_norm,
    output logic             done
);
    localparam int REF_W = $clog2(REF_BURST + 1);

    seq_state_e state_q, state_d;
    logic [REF_W-1:0] refs_q, refs_d;

    always_comb begin
        state_d   = state_q;
        refs_d    = refs_q;
        load      = 1'b0;
        load_val  = '0;
        cmd_vld   = 1'b0;
        cmd_sel   = MS_NOP;
        go_normal = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                capture  = 1'b1;
                load     = 1'b1;
                load_val = CNT_W'(POWERUP_CYC - 1);
                state_d  = ST_PWRUP;
            end
            ST_PWRUP: if (expired) begin
                cmd_vld  = 1'b1;
                cmd_sel  = MS_NOP;
                load     = 1'b1;
                load_val = CNT_W'(NOP_WAIT_CYC - 1);
                state_d  = ST_NOP_W;
            end
            ST_NOP_W: if (expired) begin
                cmd_vld  = 1'b1;
                cmd_sel  = MS_PRECH;
                load     = 1'b1;
                load_val = CNT_W'(clocks_of(cfg.rp2) - 2'd1);
                state_d  = ST_PRE_W;
            end
            ST_PRE_W: if (expired) begin
                cmd_vld  = 1'b1;
                cmd_sel  = MS_CBR;
                load     = 1'b1;
                load_val = CNT_W'(TRC_CYC - 1);
                refs_d   = REF_W'(1);
                state_d  = ST_CBR_W;
            end
            ST_CBR_W: if (expired) begin
                cmd_vld = 1'b1;
                load    = 1'b1;
                if (refs_q == REF_W'(REF_BURST)) begin
                    cmd_sel  = MS_MRS;
                    load_val = CNT_W'(MRD_CYC - 1);
                    state_d  = ST_MRS_W;
                end else begin
                    cmd_sel  = MS_CBR;
                    load_val = CNT_W'(TRC_CYC - 1);
                    refs_d   = refs_q + 1'b1;
                end
            end
            ST_MRS_W: if (expired) begin
                go_normal = 1'b1;
                state_d   = ST_NORM;
            end
            ST_NORM: state_d = ST_DONE;
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            refs_q  <= '0;
        end else begin
            state_q <= state_d;
            refs_q  <= refs_d;
        end
    end

    assign in_norm = (state_q == ST_NORM);
    assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/sis_pin_driver.sv
module sis_pin_driver
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W         = 13,
    parameter int BA_W           = 2,
    parameter int MRS_BYTE_OFS   = 'h1d0,
    parameter int BUS_BYTE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  mode_sel_e         cmd_sel,
    input  logic              go_normal,
    input  timing_cfg_t       cfg,
    output pin_cmd_t          pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output mode_sel_e         mode
);
    localparam logic [ADDR_W-1:0] MODE_BASE = ADDR_W'(MRS_BYTE_OFS >> BUS_BYTE_SHIFT);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = '0;
        if (cmd_vld) begin
            unique case (cmd_sel)
                MS_PRECH: addr_d[10] = 1'b1;
                MS_MRS: begin
                    addr_d      = MODE_BASE;
                    addr_d[6:4] = {1'b0, clocks_of(cfg.cl2)};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PINS_DESEL;
            addr <= '0;
            ba   <= '0;
            mode <= MS_NOP;
        end else begin
            pins <= encode_pins(cmd_sel, cmd_vld);
            addr <= addr_d;
            ba   <= '0;
            if (cmd_vld) begin
                mode <= cmd_sel;
            end else if (go_normal) begin
                mode <= MS_NORMAL;
            end
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int POWERUP_CYC    = 40000,
    parameter int NOP_WAIT_CYC   = 200,
    parameter int TRC_CYC        = 7,
    parameter int MRD_CYC        = 2,
    parameter int REF_BURST      = 8,
    parameter int ADDR_W         = 13,
    parameter int BA_W           = 2,
    parameter int MRS_BYTE_OFS   = 'h1d0,
    parameter int BUS_BYTE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_cl2,
    input  logic              cfg_rcd2,
    input  logic              cfg_rp2,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [2:0]        mode_code,
    output logic [1:0]        rcd_clks,
    output logic              done,
    output logic              refresh_en
);
    localparam int MAX_WAIT = max4(POWERUP_CYC, NOP_WAIT_CYC, TRC_CYC, MRD_CYC);
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    timing_cfg_t      cfg_q;
    logic             load, expired, cmd_vld, go_normal, capture, in_norm, seq_done;
    logic [CNT_W-1:0] load_val;
    mode_sel_e        cmd_sel, mode_q;
    pin_cmd_t         pins;
    logic             ref_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            ref_en_q <= 1'b0;
        end else begin
            if (capture) begin
                cfg_q <= '{cl2: cfg_cl2, rcd2: cfg_rcd2, rp2: cfg_rp2};
            end
            if (in_norm) begin
                ref_en_q <= 1'b1;
            end
        end
    end

    sis_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sis_seq_fsm #(
        .POWERUP_CYC  (POWERUP_CYC),
        .NOP_WAIT_CYC (NOP_WAIT_CYC),
        .TRC_CYC      (TRC_CYC),
        .MRD_CYC      (MRD_CYC),
        .REF_BURST    (REF_BURST),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg       (cfg_q),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .cmd_vld   (cmd_vld),
        .cmd_sel   (cmd_sel),
        .go_normal (go_normal),
        .capture   (capture),
        .in_norm   (in_norm),
        .done      (seq_done)
    );

    sis_pin_driver #(
        .ADDR_W         (ADDR_W),
        .BA_W           (BA_W),
        .MRS_BYTE_OFS   (MRS_BYTE_OFS),
        .BUS_BYTE_SHIFT (BUS_BYTE_SHIFT)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .cmd_vld   (cmd_vld),
        .cmd_sel   (cmd_sel),
        .go_normal (go_normal),
        .cfg       (cfg_q),
        .pins      (pins),
        .addr      (addr),
        .ba        (ba),
        .mode      (mode_q)
    );

    assign cs_n       = pins.cs_n;
    assign ras_n      = pins.ras_n;
    assign cas_n      = pins.cas_n;
    assign we_n       = pins.we_n;
    assign mode_code  = mode_q;
    assign rcd_clks   = clocks_of(cfg_q.rcd2);
    assign done       = seq_done;
    assign refresh_en = ref_en_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int REF_BURST = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic [2:0]        mode_code,
    input logic              done,
    input logic              refresh_en,
    input timing_cfg_t       cfg_q
);
    localparam int RC_W = $clog2(REF_BURST + 1) + 1;

    logic is_cmd, is_pre, is_cbr, is_mrs;
    assign is_cmd = !cs_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_cbr = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    logic [1:0]      since_q;
    logic [RC_W-1:0] cbr_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q    <= 2'd3;
            cbr_seen_q <= '0;
        end else begin
            if (is_cmd) since_q <= 2'd1;
            else if (since_q != 2'd3) since_q <= since_q + 2'd1;
            if (is_cbr) cbr_seen_q <= cbr_seen_q + 1'b1;
        end
    end

    // R3: precharge-all selects every bank through addr[10]
    p_pre_a10_r3: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (addr[10] && ba == '0));

    // R5: no two commands closer than two cycles
    p_min_gap_r5: assert property (@(posedge clk) disable iff (rst)
        is_cmd |-> (since_q >= 2'd2));

    // R4: the mode load follows exactly the full refresh burst
    p_burst_before_mrs_r4: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (cbr_seen_q == RC_W'(REF_BURST)));

    // R6: mode word latency field matches the captured select
    p_mrs_latency_r6: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (addr[6:4] == (cfg_q.cl2 ? 3'd2 : 3'd3)));

    // R8: done rises with refresh enable while in normal mode
    p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (refresh_en && mode_code == 3'b000));

    // R8: done is sticky and the bus stays quiet afterwards
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && refresh_en && cs_n));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .REF_BURST (REF_BURST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .ba         (ba),
    .mode_code  (mode_code),
    .done       (done),
    .refresh_en (refresh_en),
    .cfg_q      (cfg_q)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
    localparam int P    = 300;
    localparam int NW   = 200;
    localparam int TRC  = 7;
    localparam int MRD  = 2;
    localparam int RB   = 8;
    localparam int AW   = 13;
    localparam int NCMD = RB + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cfg_cl2 = 1'b0, cfg_rcd2 = 1'b0, cfg_rp2 = 1'b0;
    logic cs_n, ras_n, cas_n, we_n;
    logic [AW-1:0] addr;
    logic [1:0] ba;
    logic [2:0] mode_code;
    logic [1:0] rcd_clks;
    logic done, refresh_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .POWERUP_CYC (P), .NOP_WAIT_CYC (NW), .TRC_CYC (TRC),
        .MRD_CYC (MRD), .REF_BURST (RB), .ADDR_W (AW), .BA_W (2)
    ) u_dut (
        .clk (clk), .rst (rst), .start (start),
        .cfg_cl2 (cfg_cl2), .cfg_rcd2 (cfg_rcd2), .cfg_rp2 (cfg_rp2),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .addr (addr), .ba (ba), .mode_code (mode_code), .rcd_clks (rcd_clks),
        .done (done), .refresh_en (refresh_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pin4();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(pin4() == 4'hF, "R1 pins in reset", pin4(), 4'hF);
        rst = 1'b0;
        @(negedge clk);
        chk(pin4() == 4'hF, "R1 pins after reset", pin4(), 4'hF);
        chk(addr == '0 && ba == '0, "R1 addr/ba", int'(addr), 0);
        chk(done == 1'b0 && refresh_en == 1'b0, "R1 done/refresh_en", {done, refresh_en}, 0);
        chk(mode_code == 3'b001, "R1 mode_code", mode_code, 1);
    endtask

    // R2: without start nothing is issued
    task automatic t_no_start();
        int cmds = 0;
        for (int i = 0; i < P + 100; i++) begin
            if (!cs_n) cmds++;
            @(negedge clk);
        end
        chk(cmds == 0, "R2 no command without start", cmds, 0);
        chk(done == 1'b0 && mode_code == 3'b001, "R2 idle outputs", {done, mode_code}, 1);
    endtask

    // R2-R10 together: one full run under a configuration
    task automatic t_run(input bit cl2, input bit rcd2, input bit rp2, input bit disturb);
        int c_t[NCMD + 4];
        logic [3:0] c_p[NCMD + 4];
        logic [AW-1:0] c_a[NCMD + 4];
        logic [2:0] c_m[NCMD + 4];
        int n = 0;
        int t_norm = -1;
        int t_done = -1;
        int bad_idle = 0;
        int rp = rp2 ? 2 : 3;
        int t_pre = P + NW;
        int t_mrs = t_pre + rp + RB * TRC;
        int te = t_mrs + MRD + 8;
        logic [AW-1:0] mw = cl2 ? 13'h02A : 13'h03A;
        bit ref_early = 1'b0;
        int e_t;
        logic [3:0] e_p;
        logic [2:0] e_m;

        cfg_cl2 = cl2; cfg_rcd2 = rcd2; cfg_rp2 = rp2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int idx = 0; idx <= te; idx++) begin
            if (!cs_n) begin
                if (n < NCMD + 4) begin
                    c_t[n] = idx; c_p[n] = pin4(); c_a[n] = addr; c_m[n] = mode_code;
                end
                n++;
            end else if (pin4() != 4'hF || addr != '0 || ba != '0) begin
                bad_idle++;
            end
            if (t_norm < 0 && mode_code == 3'b000) begin
                t_norm = idx;
                if (done || refresh_en) ref_early = 1'b1;
            end
            if (t_done < 0 && done) begin
                t_done = idx;
                chk(refresh_en == 1'b1, "R8 refresh_en with done", refresh_en, 1);
            end
            if (idx == 5) chk(rcd_clks == (rcd2 ? 2'd2 : 2'd3), "R9 rcd_clks", rcd_clks, rcd2 ? 2 : 3);
            if (disturb && idx == 40) begin
                cfg_cl2 = ~cl2; cfg_rcd2 = ~rcd2; cfg_rp2 = ~rp2;
            end
            if (disturb && (idx == 60 || idx == P + NW + 1)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        chk(n == NCMD, "R4 command count", n, NCMD);
        chk(bad_idle == 0, "R3 idle cycles deselected", bad_idle, 0);
        for (int k = 0; k < NCMD && k < n; k++) begin
            if (k == 0) begin e_t = P; e_p = 4'b0111; e_m = 3'b001; end
            else if (k == 1) begin e_t = t_pre; e_p = 4'b0010; e_m = 3'b010; end
            else if (k <= RB + 1) begin e_t = t_pre + rp + (k - 2) * TRC; e_p = 4'b0001; e_m = 3'b100; end
            else begin e_t = t_mrs; e_p = 4'b0000; e_m = 3'b011; end
            chk(c_t[k] == e_t, "R5 command time", c_t[k], e_t);
            chk(c_p[k] == e_p, "R3 command pins", c_p[k], e_p);
            chk(c_m[k] == e_m, "R7 mode_code at command", c_m[k], e_m);
            if (k == 1) chk(c_a[k][10] == 1'b1, "R3 precharge A10", int'(c_a[k]), 'h400);
            if (k == NCMD - 1) chk(c_a[k] == mw, "R6 mode word", int'(c_a[k]), int'(mw));
        end
        chk(t_norm == t_mrs + MRD, "R7 normal switch time", t_norm, t_mrs + MRD);
        chk(!ref_early, "R8 flags low at normal switch", ref_early, 0);
        chk(t_done == t_norm + 1, "R8 done time", t_done, t_norm + 1);
        if (disturb) chk(rcd_clks == (rcd2 ? 2'd2 : 2'd3), "R9 rcd_clks after input change", rcd_clks, rcd2 ? 2 : 3);
    endtask

    // R10: start after done is ignored
    task automatic t_start_after_done();
        int cmds = 0;
        int lost = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < P + NW + 50; i++) begin
            if (!cs_n) cmds++;
            if (!done || !refresh_en || mode_code != 3'b000) lost++;
            @(negedge clk);
        end
        chk(cmds == 0, "R10 no command after done", cmds, 0);
        chk(lost == 0, "R10 done state kept", lost, 0);
    endtask

    initial begin
        #(5ns * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_no_start();
        t_run(1'b0, 1'b0, 1'b0, 1'b0);
        t_start_after_done();
        t_reset();
        t_run(1'b1, 1'b1, 1'b1, 1'b0);
        t_reset();
        t_run(1'b0, 1'b1, 1'b0, 1'b1);
        t_reset();
        t_run(1'b1, 1'b0, 1'b1, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule